// File: doc/BRIEF.md
# Address-Latched Program Bank Mapper

This block is the banking controller of a multi-game cartridge for an 8-bit console. The CPU programs it by writing to any address in the upper 32 KB program window. The controller takes its whole configuration from the address lines of that write. No data bus is connected to it. The latched configuration sets three things:

- the bank number placed on the high program-ROM address lines for each 16 KB half of the window;
- the nametable mirroring, which picks the console video address line routed to the video-RAM A10 pin;
- whether character RAM accepts writes.

The configuration is held in a small state register. Its layout part is an enumerated state with four values:

| State | Condition | Lower half | Upper half |
|---|---|---|---|
| `LAY_DUP` | O=1, S=0 | bank register | bank register |
| `LAY_WIDE` | O=1, S=1 | even bank of a 32 KB pair | odd bank of that pair |
| `LAY_FIRST` | O=0, L=0 | see R6 | first bank of its 8-bank block |
| `LAY_LAST` | O=0, L=1 | see R6 | last bank of its 8-bank block |

There are two transitions:

- Reset moves the block to `LAY_FIRST`, with bank 0 and vertical mirroring.
- Every accepted write moves the block to the state decoded from the write's address: bit 7 is O, bit 0 is S and bit 9 is L. Any state can go to any state, including back to itself.

Next to the layout state, the register holds a lower-half even flag, a mirroring flag and a 6-bit bank register.

Top module: `addr_latched_prg_mapper`

## Requirements
- R1: After reset, both halves map bank 0, mirroring is vertical (`ciram_a10` follows `ppu_a10`) and character RAM is writable.
- R2: A write is accepted on a rising clock edge only when `cpu_we` is 1 and `cpu_addr[15]` is 1. With `cpu_we` at 0 or `cpu_addr[15]` at 0, all outputs stay as they were.
- R3: An accepted write loads the bank register. `cpu_addr[6:2]` become bank bits 4:0 and `cpu_addr[8]` becomes bank bit 5. Address bits 14:10 have no effect.
- R4: With O=1 and S=0, both halves map the bank register value.
- R5: With O=1 and S=1, the lower half maps the bank register with bit 0 cleared and the upper half maps it with bit 0 set.
- R6: With O=0, the lower half maps the bank register when S=0, or the bank register with bit 0 cleared when S=1.
- R7: With O=0 and L=0, the upper half maps the bank register ANDed with 0x38.
- R8: With O=0 and L=1, the upper half maps the bank register ORed with 0x07.
- R9: Address bit 1 of the last accepted write selects mirroring. A 1 (horizontal) routes `ppu_a11` to `ciram_a10`; a 0 (vertical) routes `ppu_a10`.
- R10: `chr_we` equals `ppu_we` while the latched O flag is 0, and is 0 while O is 1.
- R11: A write in a cycle where `rst` is high is ignored, and reset wins.
- R12: `prg_addr` is {bank, `cpu_addr[13:0]`}. The upper-half bank is used when `cpu_addr[14]` is 1 and the lower-half bank when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_we | input | 1 | CPU write strobe |
| ppu_a10 | input | 1 | Video address line 10 |
| ppu_a11 | input | 1 | Video address line 11 |
| ppu_we | input | 1 | Video write strobe |
| prg_addr | output | 20 | Program ROM address |
| ciram_a10 | output | 1 | Video RAM A10 select |
| chr_we | output | 1 | Character RAM write enable |

## Verification
On every cycle, the assertions check several relations:

- the latched configuration holds unless a qualifying write happened, and reset leaves the cleared state;
- an accepted write captures the scattered bank bits;
- the two half banks keep their fixed relation in each layout state;
- the low program address bits pass straight through;
- the mirroring mux and the character-write gate match the latched flags.

Only the bench's scenarios show the absolute bank values expected for each mode, flag and bank combination, including the full sweep of all 64 banks across the eight mode encodings. The same holds for writes rejected by the strobe or the address qualifier, and for a write colliding with reset.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
    localparam int BANK_W = 6;
    localparam int BLK_W  = 3;

    localparam int S_BIT    = 0;
    localparam int MIR_BIT  = 1;
    localparam int BANK_LSB = 2;
    localparam int O_BIT    = 7;
    localparam int BANK_MSB = 8;
    localparam int L_BIT    = 9;

    typedef enum logic [1:0] {
        LAY_FIRST = 2'd0,
        LAY_LAST  = 2'd1,
        LAY_DUP   = 2'd2,
        LAY_WIDE  = 2'd3
    } layout_e;
endpackage

// File: rtl/mapper_latch.sv
module mapper_latch
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    output layout_e           lay_q,
    output logic              lo_even_q,
    output logic              horiz_q,
    output logic [BANK_W-1:0] bank_q
);
    logic              take;
    layout_e           lay_d;
    logic              lo_even_d;
    logic              horiz_d;
    logic [BANK_W-1:0] bank_d;

    assign take = cpu_we & cpu_addr[ADDR_W-1];

    always_comb begin
        lay_d     = lay_q;
        lo_even_d = lo_even_q;
        horiz_d   = horiz_q;
        bank_d    = bank_q;
        if (take) begin
            unique case ({cpu_addr[O_BIT], cpu_addr[S_BIT]})
                2'b11:   lay_d = LAY_WIDE;
                2'b10:   lay_d = LAY_DUP;
                default: lay_d = cpu_addr[L_BIT] ? LAY_LAST : LAY_FIRST;
            endcase
            lo_even_d = cpu_addr[S_BIT];
            horiz_d   = cpu_addr[MIR_BIT];
            bank_d    = {cpu_addr[BANK_MSB], cpu_addr[BANK_LSB +: BANK_W-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lay_q     <= LAY_FIRST;
            lo_even_q <= 1'b0;
            horiz_q   <= 1'b0;
            bank_q    <= '0;
        end else begin
            lay_q     <= lay_d;
            lo_even_q <= lo_even_d;
            horiz_q   <= horiz_d;
            bank_q    <= bank_d;
        end
    end
endmodule

// File: rtl/mapper_bank_calc.sv
module mapper_bank_calc
    import mapper_pkg::*;
(
    input  layout_e           lay,
    input  logic              lo_even,
    input  logic [BANK_W-1:0] bank,
    output logic [BANK_W-1:0] lo_bank,
    output logic [BANK_W-1:0] hi_bank
);
    localparam logic [BANK_W-1:0] BLK_MASK = BANK_W'((1 << BLK_W) - 1);
    localparam logic [BANK_W-1:0] ODD_BIT  = BANK_W'(1);

    always_comb begin
        unique case (lay)
            LAY_DUP: begin
                lo_bank = bank;
                hi_bank = bank;
            end
            LAY_WIDE: begin
                lo_bank = bank & ~ODD_BIT;
                hi_bank = bank | ODD_BIT;
            end
            LAY_FIRST: begin
                lo_bank = lo_even ? (bank & ~ODD_BIT) : bank;
                hi_bank = bank & ~BLK_MASK;
            end
            LAY_LAST: begin
                lo_bank = lo_even ? (bank & ~ODD_BIT) : bank;
                hi_bank = bank | BLK_MASK;
            end
            default: begin
                lo_bank = bank;
                hi_bank = bank;
            end
        endcase
    end
endmodule

// File: rtl/mapper_video_side.sv
module mapper_video_side (
    input  logic horiz,
    input  logic writable,
    input  logic ppu_a10,
    input  logic ppu_a11,
    input  logic ppu_we,
    output logic ciram_a10,
    output logic chr_we
);
    always_comb begin
        ciram_a10 = horiz ? ppu_a11 : ppu_a10;
        chr_we    = ppu_we & writable;
    end
endmodule

// File: rtl/addr_latched_prg_mapper.sv
module addr_latched_prg_mapper
    import mapper_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 14,
    localparam int PRG_W = BANK_W + PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    input  logic              ppu_we,
    output logic [PRG_W-1:0]  prg_addr,
    output logic              ciram_a10,
    output logic              chr_we
);
    layout_e           lay_q;
    logic              lo_even_q;
    logic              horiz_q;
    logic [BANK_W-1:0] bank_q;
    logic [BANK_W-1:0] lo_bank;
    logic [BANK_W-1:0] hi_bank;
    logic              writable;

    mapper_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .lay_q     (lay_q),
        .lo_even_q (lo_even_q),
        .horiz_q   (horiz_q),
        .bank_q    (bank_q)
    );

    mapper_bank_calc u_calc (
        .lay     (lay_q),
        .lo_even (lo_even_q),
        .bank    (bank_q),
        .lo_bank (lo_bank),
        .hi_bank (hi_bank)
    );

    assign writable = (lay_q == LAY_FIRST) || (lay_q == LAY_LAST);

    mapper_video_side u_video (
        .horiz     (horiz_q),
        .writable  (writable),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .ppu_we    (ppu_we),
        .ciram_a10 (ciram_a10),
        .chr_we    (chr_we)
    );

    always_comb begin
        prg_addr = {(cpu_addr[PAGE_W] ? hi_bank : lo_bank), cpu_addr[PAGE_W-1:0]};
    end
endmodule

// File: rtl/mapper_checker.sv
module mapper_checker
    import mapper_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic              cpu_we,
    input logic              ppu_a10,
    input logic              ppu_a11,
    input logic              ppu_we,
    input logic [19:0]       prg_addr,
    input logic              ciram_a10,
    input logic              chr_we,
    input layout_e           lay_q,
    input logic              horiz_q,
    input logic [BANK_W-1:0] bank_q,
    input logic [BANK_W-1:0] lo_bank,
    input logic [BANK_W-1:0] hi_bank
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (bank_q == '0 && lay_q == LAY_FIRST && !horiz_q));

    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cpu_we && cpu_addr[15]))
        |-> ($stable(bank_q) && $stable(lay_q) && $stable(horiz_q)));

    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cpu_we && cpu_addr[15]))
        |-> (bank_q == {$past(cpu_addr[8]), $past(cpu_addr[6:2])}));

    a_r4_dup_same: assert property (@(posedge clk) disable iff (rst)
        (lay_q == LAY_DUP) |-> (lo_bank == hi_bank && lo_bank == bank_q));

    a_r5_wide_pair: assert property (@(posedge clk) disable iff (rst)
        (lay_q == LAY_WIDE) |-> (!lo_bank[0] && hi_bank == {lo_bank[BANK_W-1:1], 1'b1}));

    a_r7_first_block: assert property (@(posedge clk) disable iff (rst)
        (lay_q == LAY_FIRST) |-> (hi_bank[2:0] == 3'd0 && hi_bank[5:3] == bank_q[5:3]));

    a_r8_last_block: assert property (@(posedge clk) disable iff (rst)
        (lay_q == LAY_LAST) |-> (hi_bank[2:0] == 3'd7 && hi_bank[5:3] == bank_q[5:3]));

    a_r9_mirror_sel: assert property (@(posedge clk) disable iff (rst)
        ciram_a10 == (horiz_q ? ppu_a11 : ppu_a10));

    a_r10_chr_gate: assert property (@(posedge clk) disable iff (rst)
        chr_we |-> (ppu_we && (lay_q == LAY_FIRST || lay_q == LAY_LAST)));

    a_r12_page_pass: assert property (@(posedge clk) disable iff (rst)
        prg_addr[13:0] == cpu_addr[13:0]);
endmodule

bind addr_latched_prg_mapper mapper_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_we    (cpu_we),
    .ppu_a10   (ppu_a10),
    .ppu_a11   (ppu_a11),
    .ppu_we    (ppu_we),
    .prg_addr  (prg_addr),
    .ciram_a10 (ciram_a10),
    .chr_we    (chr_we),
    .lay_q     (lay_q),
    .horiz_q   (horiz_q),
    .bank_q    (bank_q),
    .lo_bank   (lo_bank),
    .hi_bank   (hi_bank)
);

// File: tb/addr_latched_prg_mapper_test.sv
module addr_latched_prg_mapper_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_we = 1'b0;
    logic        ppu_a10 = 1'b0;
    logic        ppu_a11 = 1'b0;
    logic        ppu_we = 1'b0;
    logic [19:0] prg_addr;
    logic        ciram_a10;
    logic        chr_we;

    always #4 clk = ~clk;

    addr_latched_prg_mapper uut (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_we    (cpu_we),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .ppu_we    (ppu_we),
        .prg_addr  (prg_addr),
        .ciram_a10 (ciram_a10),
        .chr_we    (chr_we)
    );

    typedef struct {
        logic [19:0] prg;
        logic        ciram;
        logic        chr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    bit       m_o, m_s, m_l, m_mir;
    bit [5:0] m_bank;

    function automatic bit [5:0] half_bank(bit upper);
        if (m_o) begin
            if (m_s) return {m_bank[5:1], upper};
            return m_bank;
        end
        if (!upper) return m_s ? {m_bank[5:1], 1'b0} : m_bank;
        return m_l ? {m_bank[5:3], 3'b111} : {m_bank[5:3], 3'b000};
    endfunction

    task automatic model_reset();
        m_o = 0; m_s = 0; m_l = 0; m_mir = 0; m_bank = 6'd0;
    endtask

    task automatic model_write(input logic [15:0] a);
        m_s    = a[0];
        m_mir  = a[1];
        m_o    = a[7];
        m_l    = a[9];
        m_bank = {a[8], a[6:2]};
    endtask

    // one probe: read-side inputs applied at a falling edge, result checked by the monitor
    task automatic probe(input bit upper, input bit a10, input bit a11, input bit pwe,
                         input logic [13:0] low, input string tag);
        exp_t e;
        @(negedge clk);
        cpu_we   = 1'b0;
        cpu_addr = {1'b0, upper, low};
        ppu_a10  = a10;
        ppu_a11  = a11;
        ppu_we   = pwe;
        e.prg   = {half_bank(upper), low};
        e.ciram = m_mir ? a11 : a10;
        e.chr   = pwe & ~m_o;
        e.tag   = tag;
        q.push_back(e);
    endtask

    task automatic probe_both(input string tag);
        probe(1'b0, 1'b1, 1'b0, 1'b1, 14'h1A5C, tag);
        probe(1'b1, 1'b0, 1'b1, 1'b1, 14'h2C37, tag);
    endtask

    task automatic cpu_write(input logic [15:0] a, input bit we);
        @(negedge clk);
        cpu_addr = a;
        cpu_we   = we;
        if (we && a[15]) model_write(a);
    endtask

    function automatic logic [15:0] mk_addr(bit o, bit s, bit l, bit mir, bit [5:0] b, bit [4:0] junk);
        return {1'b1, junk, l, b[5], o, b[4:0], mir, s};
    endfunction

    always begin
        @(posedge clk);
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (prg_addr !== e.prg || ciram_a10 !== e.ciram || chr_we !== e.chr) begin
                fails++;
                $display("FAIL %s: prg=%h ciram=%b chr=%b expected prg=%h ciram=%b chr=%b",
                         e.tag, prg_addr, ciram_a10, chr_we, e.prg, e.ciram, e.chr);
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        probe_both("R1");
        probe(1'b0, 1'b0, 1'b1, 1'b1, 14'h0000, "R1");

        // R2 rejected writes: low address half, and strobe low
        cpu_write(16'h7FFF, 1'b1);
        probe_both("R2");
        cpu_write(16'hFFFF, 1'b0);
        probe_both("R2");

        // R4 and R3: O=1 S=0, bank 0x2D
        cpu_write(mk_addr(1, 0, 0, 0, 6'h2D, 5'h00), 1'b1);
        probe_both("R4");
        // R3 junk address bits 14:10 do not matter
        cpu_write(mk_addr(1, 0, 0, 0, 6'h2D, 5'h1F), 1'b1);
        probe_both("R3");
        // R5 32 KB pair, odd register value
        cpu_write(mk_addr(1, 1, 0, 1, 6'h13, 5'h0A), 1'b1);
        probe_both("R5");
        probe(1'b0, 1'b1, 1'b1, 1'b1, 14'h3FFF, "R10");
        // R7 and R6 with S=0 then S=1
        cpu_write(mk_addr(0, 0, 0, 0, 6'h2F, 5'h00), 1'b1);
        probe_both("R7");
        cpu_write(mk_addr(0, 1, 0, 1, 6'h2F, 5'h00), 1'b1);
        probe_both("R6");
        // R8 last bank of block
        cpu_write(mk_addr(0, 0, 1, 0, 6'h21, 5'h05), 1'b1);
        probe_both("R8");
        cpu_write(mk_addr(0, 1, 1, 1, 6'h21, 5'h05), 1'b1);
        probe_both("R8");
        // R9 mirroring both ways, ppu lines distinct
        cpu_write(mk_addr(0, 0, 0, 1, 6'h05, 5'h00), 1'b1);
        probe(1'b0, 1'b0, 1'b1, 1'b0, 14'h0123, "R9");
        probe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0123, "R9");
        cpu_write(mk_addr(0, 0, 0, 0, 6'h05, 5'h00), 1'b1);
        probe(1'b0, 1'b0, 1'b1, 1'b0, 14'h0123, "R9");
        probe(1'b0, 1'b1, 1'b0, 1'b0, 14'h0123, "R9");

        // R11 write colliding with reset
        cpu_write(mk_addr(1, 1, 1, 1, 6'h3F, 5'h1F), 1'b1);
        @(negedge clk);
        rst      = 1'b1;
        cpu_addr = mk_addr(1, 0, 1, 1, 6'h2A, 5'h00);
        cpu_we   = 1'b1;
        model_reset();
        @(negedge clk);
        rst    = 1'b0;
        cpu_we = 1'b0;
        probe_both("R11");

        // R12 and R3 sweep: every bank, every mode encoding
        for (int b = 0; b < 64; b++) begin
            for (int m = 0; m < 8; m++) begin
                cpu_write(mk_addr(m[2], m[1], m[0], b[0] ^ m[2], b[5:0], b[4:0]), 1'b1);
                probe(1'b0, 1'b1, 1'b0, 1'b1, 14'(b * 211 + m), "R12 sweep");
                probe(1'b1, 1'b0, 1'b1, 1'b1, 14'(b * 97 + m), "R12 sweep");
            end
        end

        repeat (3) @(posedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule